// File: doc/BRIEF.md
# Iterative Integer Divide Unit

A multi-cycle 32-bit integer divider for a simple in-order processor. An issuing stage presents a divide instruction word together with the two register values it names, and pulses a start strobe. The unit divides the second source value by the first, in either unsigned or two's-complement signed arithmetic as chosen by one bit of the instruction. When it finishes, it pulses a done strobe carrying the quotient, the destination register index and a write enable for the register file.

Two operand patterns are handled apart from the normal division. A zero divisor finishes in a single cycle with a zero result. The one signed quotient that cannot be represented, the most negative value divided by minus one, runs the full latency and yields the most negative value. Both cases set a sticky divide status flag and load a five-bit exception class with a sub-code that tells them apart. When the exception-enable input is high at start, either case suppresses the register write. A parameter selects a faster variant with a latency of 32 cycles, or a smaller one with 34 cycles that registers the sign handling on each side of the loop.

Top module: `div_unit`

## Requirements
- R1: The instruction is a divide when `instr_i[31:26]` is 010010 and `instr_i[10:2]` and `instr_i[0]` are zero. Fields: destination index `instr_i[25:21]`, divisor index `instr_i[20:16]`, dividend index `instr_i[15:11]`, unsigned select `instr_i[1]`. `ra_idx_o`/`rb_idx_o` show the divisor and dividend indices combinationally.
- R2: A start is accepted only when the unit is idle and the instruction is a divide. Otherwise it is ignored, produces no done pulse, and does not disturb a division in progress.
- R3: With the unsigned select at 1, `quot_o` equals `op_b_i / op_a_i` with both values unsigned.
- R4: With the unsigned select at 0, both values are signed and `quot_o` is the signed quotient truncated toward zero.
- R5: A zero `op_a_i` gives `done_o` one cycle after the accepting edge, `quot_o` = 0, `dzo_o` = 1, `exc_class_o` = 5'b00101 and `exc_sub_o` = 0.
- R6: In signed mode, `op_a_i` = 32'hFFFFFFFF with `op_b_i` = 32'h80000000 gives `quot_o` = 32'h80000000, `dzo_o` = 1, `exc_class_o` = 5'b00101, `exc_sub_o` = 1, at normal latency.
- R7: Any non-zero divisor gives `done_o` 32 cycles after the accepting edge with `AREA_OPT` = 0, or 34 cycles with `AREA_OPT` = 1.
- R8: `wr_en_o` pulses with `done_o`, except when `exc_en_i` was 1 at start and the operation hit the R5 or R6 case, when it stays 0.
- R9: A normal division leaves `dzo_o`, `exc_class_o` and `exc_sub_o` at their previous values.
- R10: `done_o` is high for exactly one cycle, and `rd_idx_o` then holds the destination index of the accepted instruction.
- R11: After reset `busy_o`, `done_o`, `wr_en_o`, `dzo_o`, `exc_class_o` and `exc_sub_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| instr_i | input | 32 | Divide instruction word |
| op_a_i | input | 32 | Divisor value (first source register) |
| op_b_i | input | 32 | Dividend value (second source register) |
| exc_en_i | input | 1 | Divide exception enable |
| ra_idx_o | output | 5 | Divisor register index |
| rb_idx_o | output | 5 | Dividend register index |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result valid, one-cycle pulse |
| quot_o | output | 32 | Quotient |
| wr_en_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| dzo_o | output | 1 | Sticky divide status flag |
| exc_class_o | output | 5 | Exception class code |
| exc_sub_o | output | 1 | Exception sub-code: 0 zero divisor, 1 overflow |

## Verification
Unsigned vectors use dividends with the top bit set, which a signed path would misread, and a dividend smaller than its divisor. Signed vectors take each of the four sign combinations, so a missing or wrong negation shows up. They also include the largest positive dividend over minus one and the most negative dividend over one, which sit just beside the overflow case. The zero-divisor and overflow cases run with the exception enable both set and clear, and each is followed by a normal division to show the status outputs are left alone. Separate tests send a second start during a division and a start with a corrupted instruction word.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam logic [5:0] OPC_DIV       = 6'b010010;
  localparam logic [4:0] EXC_CLASS_DIV = 5'b00101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_RUN,
    ST_FIX,
    ST_ZERO
  } div_state_e;
endpackage

// File: rtl/div_decode.sv
module div_decode (
  input  logic [31:0] instr_i,
  output logic [4:0]  rd_o,
  output logic [4:0]  ra_o,
  output logic [4:0]  rb_o,
  output logic        uns_o,
  output logic        valid_o
);
  import div_pkg::*;

  assign rd_o    = instr_i[25:21];
  assign ra_o    = instr_i[20:16];
  assign rb_o    = instr_i[15:11];
  assign uns_o   = instr_i[1];
  assign valid_o = (instr_i[31:26] == OPC_DIV) && (instr_i[10:2] == '0) && !instr_i[0];
endmodule

// File: rtl/div_special.sv
module div_special #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvs_i,
  input  logic [W-1:0] dvd_i,
  input  logic         uns_i,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  assign zero_o = (dvs_i == '0);
  assign ovf_o  = !uns_i && (dvs_i == '1) && (dvd_i == MOST_NEG);
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvd_o
);
  logic [W:0] shifted;
  logic [W:0] trial;
  logic       qbit;

  assign shifted = {rem_i, dvd_i[W-1]};
  assign trial   = shifted - {1'b0, dvs_i};
  assign qbit    = !trial[W];
  assign rem_o   = qbit ? trial[W-1:0] : shifted[W-1:0];
  assign dvd_o   = {dvd_i[W-2:0], qbit};
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int W        = 32,
  parameter bit AREA_OPT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [31:0]  instr_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         exc_en_i,
  output logic [4:0]   ra_idx_o,
  output logic [4:0]   rb_idx_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         wr_en_o,
  output logic [4:0]   rd_idx_o,
  output logic         dzo_o,
  output logic [4:0]   exc_class_o,
  output logic         exc_sub_o
);
  import div_pkg::*;

  localparam int           CNT_W    = $clog2(W);
  localparam int           LAT      = AREA_OPT ? W + 2 : W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  div_state_e   state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0] rem_q, dvd_q, dvs_q;
  logic         neg_q, ovf_q, uns_q, exc_en_q;
  logic [W-1:0] rem_n, dvd_n;

  logic [4:0] dec_rd;
  logic       dec_uns, dec_valid;
  logic       is_zero, is_ovf;
  logic       accept;
  logic       last_iter;
  logic [W-1:0] mag_a, mag_b;

  div_decode u_decode (
    .instr_i (instr_i),
    .rd_o    (dec_rd),
    .ra_o    (ra_idx_o),
    .rb_o    (rb_idx_o),
    .uns_o   (dec_uns),
    .valid_o (dec_valid)
  );

  div_special #(.W(W)) u_special (
    .dvs_i  (op_a_i),
    .dvd_i  (op_b_i),
    .uns_i  (dec_uns),
    .zero_o (is_zero),
    .ovf_o  (is_ovf)
  );

  div_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .dvd_i (dvd_q),
    .dvs_i (dvs_q),
    .rem_o (rem_n),
    .dvd_o (dvd_n)
  );

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic uns);
    return (!uns && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  assign busy_o    = (state_q != ST_IDLE);
  assign accept    = start_i && dec_valid && !busy_o;
  assign last_iter = (cnt_q == CNT_W'(W - 1));
  assign mag_a     = magnitude(op_a_i, dec_uns);
  assign mag_b     = magnitude(op_b_i, dec_uns);

  // sign correction applied to the raw magnitude quotient
  logic [W-1:0] fix_src, fix_q;
  generate
    if (AREA_OPT) begin : g_area_src
      assign fix_src = dvd_q;
    end else begin : g_speed_src
      assign fix_src = dvd_n;
    end
  endgenerate
  assign fix_q = ovf_q ? MOST_NEG : (neg_q ? (~fix_src + 1'b1) : fix_src);

  logic finish;
  assign finish = AREA_OPT ? (state_q == ST_FIX) : (state_q == ST_RUN && last_iter);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rem_q       <= '0;
      dvd_q       <= '0;
      dvs_q       <= '0;
      neg_q       <= 1'b0;
      ovf_q       <= 1'b0;
      uns_q       <= 1'b0;
      exc_en_q    <= 1'b0;
      rd_idx_o    <= '0;
      quot_o      <= '0;
      done_o      <= 1'b0;
      wr_en_o     <= 1'b0;
      dzo_o       <= 1'b0;
      exc_class_o <= '0;
      exc_sub_o   <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rd_idx_o <= dec_rd;
            exc_en_q <= exc_en_i;
            uns_q    <= dec_uns;
            ovf_q    <= is_ovf;
            neg_q    <= !dec_uns && (op_a_i[W-1] ^ op_b_i[W-1]);
            rem_q    <= '0;
            cnt_q    <= '0;
            if (is_zero) begin
              state_q <= ST_ZERO;
            end else if (AREA_OPT) begin
              dvd_q   <= op_b_i;
              dvs_q   <= op_a_i;
              state_q <= ST_CONV;
            end else begin
              dvd_q   <= mag_b;
              dvs_q   <= mag_a;
              state_q <= ST_RUN;
            end
          end
        end
        ST_CONV: begin
          dvd_q   <= magnitude(dvd_q, uns_q);
          dvs_q   <= magnitude(dvs_q, uns_q);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_n;
          dvd_q <= dvd_n;
          cnt_q <= cnt_q + 1'b1;
          if (last_iter && AREA_OPT) state_q <= ST_FIX;
        end
        ST_ZERO: begin
          done_o      <= 1'b1;
          quot_o      <= '0;
          wr_en_o     <= !exc_en_q;
          dzo_o       <= 1'b1;
          exc_class_o <= EXC_CLASS_DIV;
          exc_sub_o   <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: ;
      endcase
      if (finish) begin
        done_o  <= 1'b1;
        quot_o  <= fix_q;
        wr_en_o <= !(ovf_q && exc_en_q);
        state_q <= ST_IDLE;
        if (ovf_q) begin
          dzo_o       <= 1'b1;
          exc_class_o <= EXC_CLASS_DIV;
          exc_sub_o   <= 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic [6:0] lat_q;
  logic       was_zero_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= '0;
      was_zero_q <= 1'b0;
    end else if (accept) begin
      lat_q      <= '0;
      was_zero_q <= is_zero;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_zero_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && was_zero_q |-> lat_q == 7'd1);

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !was_zero_q |-> lat_q == 7'(LAT));

  p_exc_class_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && was_zero_q |-> dzo_o && exc_class_o == EXC_CLASS_DIV && !exc_sub_o);

  p_ovf_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ovf_q |-> quot_o == MOST_NEG && exc_sub_o && dzo_o);

  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && exc_en_q && (ovf_q || was_zero_q) |-> !wr_en_o);

  p_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  p_flags_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ovf_q && !was_zero_q |-> $stable(dzo_o) && $stable(exc_class_o) && $stable(exc_sub_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);

  p_bad_instr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !dec_valid |=> !busy_o);
endmodule

// File: tb/tb_div_unit.sv
module tb_div_unit;
  localparam bit AREA = 1'b0;
  localparam int LAT  = AREA ? 34 : 32;
  localparam int NV   = 11;

  // {unsigned, divisor, dividend, quotient}
  localparam logic [96:0] VEC [NV] = '{
    {1'b1, 32'd7,        32'd100,      32'd14},
    {1'b1, 32'd2,        32'hFFFFFFFF, 32'h7FFFFFFF},
    {1'b1, 32'd9,        32'd5,        32'd0},
    {1'b1, 32'h80000000, 32'h80000000, 32'd1},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1},
    {1'b0, 32'd7,        32'hFFFFFF9C, 32'hFFFFFFF2},
    {1'b0, 32'hFFFFFFF9, 32'd100,      32'hFFFFFFF2},
    {1'b0, 32'hFFFFFFF9, 32'hFFFFFF9C, 32'd14},
    {1'b0, 32'd1,        32'h80000000, 32'h80000000},
    {1'b0, 32'hFFFFFFFF, 32'd7,        32'hFFFFFFF9},
    {1'b0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        exc_en = 1'b0;
  logic [4:0]  ra_idx, rb_idx, rd_idx;
  logic        busy, done, wr_en, dzo, exc_sub;
  logic [31:0] quot;
  logic [4:0]  exc_class;

  int checks = 0;
  int errors = 0;
  int lat_seen;
  logic [31:0] q_seen;
  logic        wr_seen;
  logic [4:0]  rd_seen;

  always #5 clk = ~clk;

  div_unit #(.W(32), .AREA_OPT(AREA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .op_a_i(op_a), .op_b_i(op_b), .exc_en_i(exc_en),
    .ra_idx_o(ra_idx), .rb_idx_o(rb_idx), .busy_o(busy), .done_o(done),
    .quot_o(quot), .wr_en_o(wr_en), .rd_idx_o(rd_idx), .dzo_o(dzo),
    .exc_class_o(exc_class), .exc_sub_o(exc_sub)
  );

  function automatic logic [31:0] mk_instr(input logic [4:0] rd, input logic [4:0] ra,
                                           input logic [4:0] rb, input logic u);
    return {6'b010010, rd, ra, rb, 9'b0, u, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one divide and wait for done; sampled on falling edges
  task automatic run_op(input logic u, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] rd, input logic en);
    @(negedge clk);
    instr = mk_instr(rd, 5'd3, 5'd4, u);
    op_a = a; op_b = b; exc_en = en; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat_seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      @(posedge clk);
      lat_seen++;
      @(negedge clk);
    end
    q_seen = quot; wr_seen = wr_en; rd_seen = rd_idx;
    @(negedge clk);
    check("R10 done single cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset busy", {31'b0, busy}, 32'd0);
    check("R11 reset done/wr", {30'b0, done, wr_en}, 32'd0);
    check("R11 reset flags", {26'b0, dzo, exc_class}, 32'd0);
    check("R11 reset sub", {31'b0, exc_sub}, 32'd0);
    rst_n = 1'b1;

    instr = mk_instr(5'd9, 5'd17, 5'd30, 1'b1);
    #1;
    check("R1 divisor index", {27'b0, ra_idx}, 32'd17);
    check("R1 dividend index", {27'b0, rb_idx}, 32'd30);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][96], VEC[v][95:64], VEC[v][63:32], 5'(v + 1), 1'b1);
      check(VEC[v][96] ? "R3 unsigned quotient" : "R4 signed quotient", q_seen, VEC[v][31:0]);
      check("R7 latency", lat_seen, LAT);
      check("R8 write normal", {31'b0, wr_seen}, 32'd1);
      check("R10 rd index", {27'b0, rd_seen}, 32'(v + 1));
      check("R9 flags untouched", {26'b0, dzo, exc_class}, 32'd0);
    end

    // zero divisor, exception disabled
    run_op(1'b0, 32'd0, 32'd55, 5'd20, 1'b0);
    check("R5 zero latency", lat_seen, 1);
    check("R5 zero result", q_seen, 32'd0);
    check("R5 zero flags", {25'b0, dzo, exc_class, exc_sub}, {25'b0, 1'b1, 5'b00101, 1'b0});
    check("R8 zero write when disabled", {31'b0, wr_seen}, 32'd1);

    run_op(1'b1, 32'd3, 32'd9, 5'd2, 1'b1);
    check("R9 flags kept after zero", {25'b0, dzo, exc_class, exc_sub}, {25'b0, 1'b1, 5'b00101, 1'b0});
    check("R3 quotient after zero", q_seen, 32'd3);

    // signed overflow, exception enabled
    run_op(1'b0, 32'hFFFFFFFF, 32'h80000000, 5'd21, 1'b1);
    check("R6 ovf result", q_seen, 32'h80000000);
    check("R6 ovf latency", lat_seen, LAT);
    check("R6 ovf flags", {25'b0, dzo, exc_class, exc_sub}, {25'b0, 1'b1, 5'b00101, 1'b1});
    check("R8 ovf write blocked", {31'b0, wr_seen}, 32'd0);

    // same operands unsigned: no overflow
    run_op(1'b1, 32'hFFFFFFFF, 32'h80000000, 5'd22, 1'b1);
    check("R3 unsigned near ovf", q_seen, 32'd0);
    check("R9 sub kept", {31'b0, exc_sub}, 32'd1);

    // zero divisor, exception enabled
    run_op(1'b1, 32'd0, 32'd1, 5'd23, 1'b1);
    check("R8 zero write blocked", {31'b0, wr_seen}, 32'd0);
    check("R5 sub cleared", {31'b0, exc_sub}, 32'd0);

    // start while busy is ignored
    @(negedge clk);
    instr = mk_instr(5'd5, 5'd1, 5'd2, 1'b1);
    op_a = 32'd10; op_b = 32'd1000; exc_en = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat_seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      if (i == 3) begin
        instr = mk_instr(5'd6, 5'd1, 5'd2, 1'b1);
        op_a = 32'd5; op_b = 32'd50; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat_seen++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R2 busy start ignored result", quot, 32'd100);
    check("R2 busy start ignored rd", {27'b0, rd_idx}, 32'd5);
    check("R2 busy start latency", lat_seen, LAT);
    @(negedge clk);
    check("R2 no second done", {30'b0, done, busy}, 32'd0);

    // malformed instruction is ignored
    @(negedge clk);
    instr = mk_instr(5'd7, 5'd1, 5'd2, 1'b1) | 32'h0000_0001;
    op_a = 32'd2; op_b = 32'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || busy) seen = 1;
      end
      check("R2 bad instr ignored", seen, 0);
    end
    instr = {6'b010011, 26'd0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R1 wrong opcode ignored", {31'b0, busy}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule